// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of instruction bytes filled ahead of the execution side. It sits between a 16-bit-wide memory port and a consumer that takes one code byte at a time. When the store has room for a whole bus word and the execution side has not asked for the bus, the block starts a word-wide code read at its fetch offset. It appends the returned bytes in address order and moves the offset forward.

The execution side can ask for a data read or write through the same memory port. Such a request wins over any new code read. A code read that is already on the bus always finishes first. A control transfer is signalled with a one-cycle flush pulse and a 16-bit target offset. The flush empties the store and moves the fetch offset to the target. Any code read still on the bus at that moment finishes, and its data is thrown away. For a data read, the execution side takes the read data straight from the memory port's read-data lines in the cycle where `d_done` is high.

Top module: `pfq_top`

## Requirements
- R1: The consumer receives code bytes in ascending address order, starting at the most recent flush target (or offset 0 after reset). Byte at address a of a word read sits on read-data bits [7:0] when a is even and on [15:8] when a is odd. `cons_byte` is the oldest byte whenever `cons_valid` is high. The store never holds more than DEPTH bytes.
- R2: With no data request pending and fewer than two free byte slots, the block starts no bus transaction. A data request is still served when the store is full.
- R3: A code read starts only from an idle bus with at least two free slots and no data request. It starts again as soon as consumption frees the second slot.
- R4: A data request raised during a code read waits for that read's acknowledge. It is the very next transaction, with `mem_code` low and `mem_addr` equal to `d_addr`. `d_done` pulses with its acknowledge. Address, kind and write fields stay stable while a transaction awaits its acknowledge.
- R5: In the cycle after a flush pulse `cons_valid` is low, whatever the store held. A pop requested together with a flush is ignored.
- R6: A code read at an odd fetch offset keeps only the upper byte and advances the offset by one. At an even offset both bytes are kept and the offset advances by two. The read itself is always issued with `mem_addr` bit 0 cleared.
- R7: Data returned for a code read that was on the bus when a flush arrived never enters the store. This includes a flush in the same cycle as the acknowledge.
- R8: A pop and an append in the same cycle are both honoured, so a consumer popping every cycle is fed without lost or repeated bytes.
- R9: The fetch offset wraps modulo 2^AW, so the byte after address 0xFFFF (with AW=16) is address 0x0000.
- R10: While `rst_n` is low, `mem_req` and `cons_valid` are low. After reset the first code read is at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cons_valid | output | 1 | At least one code byte is available |
| cons_byte | output | 8 | Oldest code byte |
| cons_pop | input | 1 | Remove the oldest byte (ignored when empty) |
| flush | input | 1 | Control transfer: discard all bytes, refetch from `flush_addr` |
| flush_addr | input | AW | Target offset loaded on flush |
| d_req | input | 1 | Execution-side data access request, held until `d_done` |
| d_we | input | 1 | Data access is a write |
| d_addr | input | AW | Data access byte offset |
| d_wdata | input | 16 | Data write value |
| d_done | output | 1 | Data access acknowledged this cycle |
| mem_req | output | 1 | Memory transaction pending |
| mem_code | output | 1 | Pending transaction is a code read |
| mem_we | output | 1 | Pending transaction is a write |
| mem_addr | output | AW | Transaction byte offset (bit 0 clear for code reads) |
| mem_wdata | output | 16 | Write value |
| mem_ack | input | 1 | Memory completes the pending transaction this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |

## Verification
The bench builds the block with DEPTH=6 and AW=16. With that depth, every fill level from empty to full can be reached in a few cycles, including the one-free-slot level where fetching must pause. Flush targets near 0xFFFF can reach the full 16-bit offset space, so offset wrap is swept together with odd and even starts. Memory latency is varied from zero to three wait cycles. Flushes and data requests are placed at each cycle of an in-flight code read, including the acknowledge cycle.

// File: rtl/pfq_pkg.sv
// Shared types for the prefetch byte queue.
// Assumes a single outstanding memory transaction at any time.
package pfq_pkg;

    // Bus owner state: idle, code read in flight, data access in flight.
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_CODE = 2'd1,
        BUS_DATA = 2'd2
    } bus_state_e;

    // Bytes to append this cycle: n in {0,1,2}; b0 goes in first.
    typedef struct packed {
        logic [1:0] n;
        logic [7:0] b1;
        logic [7:0] b0;
    } push_t;

endpackage

// File: rtl/pfq_byte_queue.sv
// Byte store of DEPTH entries, head always in slot 0.
// Accepts one pop and up to two appended bytes per cycle; clear empties it.
// Assumes the caller never appends more bytes than there are free slots.
module pfq_byte_queue #(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 pop,
    input  pfq_pkg::push_t       push,
    output logic [7:0]           head,
    output logic [CW-1:0]        count
);
    logic [7:0]    slot_q [DEPTH];
    logic [7:0]    slot_d [DEPTH];
    logic [CW-1:0] count_q;
    logic [CW-1:0] count_d;
    logic [CW-1:0] base;
    logic          do_pop;

    assign do_pop = pop && (count_q != '0);

    // Next contents: shift on pop, then drop new bytes behind the survivors.
    always_comb begin
        base = count_q - CW'(do_pop);
        for (int i = 0; i < DEPTH; i++) begin
            if (do_pop && (i < DEPTH - 1)) begin
                slot_d[i] = slot_q[(i + 1) % DEPTH];
            end else begin
                slot_d[i] = slot_q[i];
            end
            if ((push.n != 2'd0) && (CW'(i) == base)) begin
                slot_d[i] = push.b0;
            end
            if ((push.n == 2'd2) && (CW'(i) == base + CW'(1))) begin
                slot_d[i] = push.b1;
            end
        end
        count_d = clear ? '0 : base + CW'(push.n);
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // Byte slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign head  = slot_q[0];
    assign count = count_q;

endmodule

// File: rtl/pfq_fetch_ctl.sv
// Fetch offset counter and return-data steering.
// Turns a completed code read into 1 or 2 appended bytes depending on
// the offset parity, and drops reads that a flush has made stale.
// Assumes the offset does not move while a code read is in flight
// except through flush.
module pfq_fetch_ctl #(
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [AW-1:0]        flush_addr,
    input  logic                 code_busy,
    input  logic                 code_done,
    input  logic [15:0]          rdata,
    output logic [AW-1:0]        ptr,
    output pfq_pkg::push_t       push
);
    logic [AW-1:0] ptr_q;
    logic          drop_q;

    // Steer returned word into queue bytes; odd offset keeps the upper byte.
    always_comb begin
        push = '0;
        if (code_done && !drop_q && !flush) begin
            if (ptr_q[0]) begin
                push.n  = 2'd1;
                push.b0 = rdata[15:8];
            end else begin
                push.n  = 2'd2;
                push.b0 = rdata[7:0];
                push.b1 = rdata[15:8];
            end
        end
    end

    // Fetch offset: reload on flush, else advance by bytes kept (wraps).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (flush) begin
            ptr_q <= flush_addr;
        end else if (push.n != 2'd0) begin
            ptr_q <= ptr_q + AW'(push.n);
        end
    end

    // Stale-read marker: set by a flush during a code read, cleared at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (code_done) begin
            drop_q <= 1'b0;
        end else if (flush && code_busy) begin
            drop_q <= 1'b1;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/pfq_bus_arb.sv
// Memory port owner: starts one transaction at a time from idle,
// data requests first, code reads only with room and no flush.
// Holds request fields until mem_ack; returns to idle for one cycle after.
module pfq_bus_arb #(
    parameter int AW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    d_req,
    input  logic                    d_we,
    input  logic [AW-1:0]           d_addr,
    input  logic [15:0]             d_wdata,
    input  logic                    room_ok,
    input  logic                    flush,
    input  logic [AW-1:0]           code_addr,
    input  logic                    mem_ack,
    output logic                    code_busy,
    output logic                    code_done,
    output logic                    data_done,
    output logic                    mem_req,
    output logic                    mem_code,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [15:0]             mem_wdata
);
    import pfq_pkg::*;

    bus_state_e    state_q;
    logic          idle;
    logic          start_data;
    logic          start_code;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [15:0]   wdata_q;

    assign idle       = (state_q == BUS_IDLE);
    assign start_data = idle && d_req;
    assign start_code = idle && !d_req && room_ok && !flush;

    // Owner state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            case (state_q)
                BUS_IDLE: begin
                    if (start_data) begin
                        state_q <= BUS_DATA;
                    end else if (start_code) begin
                        state_q <= BUS_CODE;
                    end
                end
                BUS_CODE, BUS_DATA: begin
                    if (mem_ack) begin
                        state_q <= BUS_IDLE;
                    end
                end
                default: state_q <= BUS_IDLE;
            endcase
        end
    end

    // Capture transaction fields at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= 16'h0000;
        end else if (start_data) begin
            addr_q  <= d_addr;
            we_q    <= d_we;
            wdata_q <= d_wdata;
        end else if (start_code) begin
            addr_q  <= {code_addr[AW-1:1], 1'b0};
            we_q    <= 1'b0;
        end
    end

    assign code_busy = (state_q == BUS_CODE);
    assign code_done = code_busy && mem_ack;
    assign data_done = (state_q == BUS_DATA) && mem_ack;
    assign mem_req   = !idle;
    assign mem_code  = code_busy;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/pfq_top.sv
// Instruction prefetch byte queue: keeps up to DEPTH code bytes ahead of
// the consumer, fetching 16-bit words when two slots are free, yielding the
// bus to data accesses between code reads, and refilling from a new offset
// on flush. Assumes a memory port that completes one request at a time.
module pfq_top #(
    parameter int DEPTH = 6,
    parameter int AW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cons_valid,
    output logic [7:0]        cons_byte,
    input  logic              cons_pop,
    input  logic              flush,
    input  logic [AW-1:0]     flush_addr,
    input  logic              d_req,
    input  logic              d_we,
    input  logic [AW-1:0]     d_addr,
    input  logic [15:0]       d_wdata,
    output logic              d_done,
    output logic              mem_req,
    output logic              mem_code,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]  q_count;
    logic           room_ok;
    logic           code_busy;
    logic           code_done;
    logic [AW-1:0]  fetch_ptr;
    pfq_pkg::push_t push;

    assign room_ok    = (q_count <= CW'(DEPTH - 2));
    assign cons_valid = (q_count != '0);

    pfq_byte_queue #(.DEPTH(DEPTH), .CW(CW)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (flush),
        .pop   (cons_pop && !flush),
        .push  (push),
        .head  (cons_byte),
        .count (q_count)
    );

    pfq_fetch_ctl #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_addr (flush_addr),
        .code_busy  (code_busy),
        .code_done  (code_done),
        .rdata      (mem_rdata),
        .ptr        (fetch_ptr),
        .push       (push)
    );

    pfq_bus_arb #(.AW(AW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_req     (d_req),
        .d_we      (d_we),
        .d_addr    (d_addr),
        .d_wdata   (d_wdata),
        .room_ok   (room_ok),
        .flush     (flush),
        .code_addr (fetch_ptr),
        .mem_ack   (mem_ack),
        .code_busy (code_busy),
        .code_done (code_done),
        .data_done (d_done),
        .mem_req   (mem_req),
        .mem_code  (mem_code),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/pfq_checker.sv
// Protocol and occupancy properties of pfq_top, attached by bind.
module pfq_checker #(
    parameter int DEPTH = 6,
    parameter int AW    = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          d_req,
    input logic          mem_req,
    input logic          mem_code,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          cons_valid,
    input logic [CW-1:0] count
);
    // R10: reset keeps the port quiet and the queue empty
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !cons_valid));

    // R1: occupancy never exceeds the depth
    a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: a code read only starts with two or more free slots
    a_r3_room_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_code) |-> ($past(count) <= CW'(DEPTH - 2)));

    // R2: idle, no data request and under two free slots keeps the bus idle
    a_r2_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !d_req && (count > CW'(DEPTH - 2))) |=> !mem_req);

    // R4: pending transaction fields hold until acknowledged
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_code)));

    // R4: an idle bus with a data request starts the data access
    a_r4_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && d_req) |=> (mem_req && !mem_code));

    // R5: flush leaves nothing to consume
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !cons_valid);

endmodule

bind pfq_top pfq_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .d_req      (d_req),
    .mem_req    (mem_req),
    .mem_code   (mem_code),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .cons_valid (cons_valid),
    .count      (q_count)
);

// File: tb/sim_pfq_top.sv
`timescale 1ns/1ps
module sim_pfq_top;
    localparam int DEPTH = 6;
    localparam int AW    = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          cons_valid, cons_pop;
    logic [7:0]    cons_byte;
    logic          flush;
    logic [15:0]   flush_addr;
    logic          d_req, d_we, d_done;
    logic [15:0]   d_addr, d_wdata;
    logic          mem_req, mem_code, mem_we, mem_ack;
    logic [15:0]   mem_addr, mem_wdata, mem_rdata;

    pfq_top #(.DEPTH(DEPTH), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cons_valid(cons_valid), .cons_byte(cons_byte),
        .cons_pop(cons_pop), .flush(flush), .flush_addr(flush_addr),
        .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
        .d_done(d_done), .mem_req(mem_req), .mem_code(mem_code), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Bench memory contents: byte at address a.
    function automatic logic [7:0] mb(input logic [15:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd13;
        return t ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Control shared between the main sequence and the edge driver.
    int          pop_mode = 0;
    bit          pop_once = 0;
    bit          flush_go = 0;
    bit          dreq_go  = 0;
    logic [15:0] flush_tgt = 0;
    logic [15:0] exp_addr  = 0;
    int          lat = 1;
    int          code_starts = 0;
    logic [15:0] last_code_addr = 0;
    int          data_acks = 0;
    int          done_seen = 0;
    int          pops = 0;
    bit          post_flush = 0;
    bit          pend_data = 0;
    int          cyc = 0;
    bit          in_txn = 0;
    int          lat_cnt = 0;
    bit          txn_code = 0;
    logic [15:0] txn_addr = 0;
    bit          first_code_seen = 0;

    // Memory responder, consumer, flush and data-request driver (falling edge).
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            mem_ack = 0; in_txn = 0; cons_pop = 0; flush = 0; d_req = 0;
        end else begin
            if (mem_req) begin
                if (!in_txn) begin
                    in_txn = 1; lat_cnt = 0; txn_code = mem_code; txn_addr = mem_addr;
                    if (pend_data) begin
                        chk(!mem_code, "R4 data access follows the code read", mem_code, 0);
                        pend_data = 0;
                    end
                    if (mem_code) begin
                        code_starts++;
                        last_code_addr = mem_addr;
                        chk(mem_addr[0] == 1'b0, "R6 code read word aligned", mem_addr, mem_addr & 16'hFFFE);
                        if (!first_code_seen) begin
                            first_code_seen = 1;
                            chk(mem_addr == 16'h0000, "R10 first fetch at offset 0", mem_addr, 0);
                        end
                    end else begin
                        chk(mem_addr == d_addr, "R4 data address", mem_addr, d_addr);
                    end
                end else if (mem_code !== txn_code || mem_addr !== txn_addr) begin
                    chk(0, "R4 transaction held until ack", mem_addr, txn_addr);
                end
                if (lat_cnt >= lat) begin
                    mem_ack = 1; in_txn = 0;
                    if (txn_code) begin
                        mem_rdata = {mb(txn_addr + 16'd1), mb(txn_addr)};
                        if (d_req) pend_data = 1;
                    end else begin
                        mem_rdata = 16'hD00D;
                        d_req = 0;
                        data_acks++;
                    end
                end else begin
                    mem_ack = 0;
                    lat_cnt++;
                end
            end else begin
                mem_ack = 0; in_txn = 0;
            end

            if (post_flush) begin
                chk(!cons_valid, "R5 empty after flush", cons_valid, 0);
                post_flush = 0;
            end
            cons_pop = 0;
            if (flush_go) begin
                flush = 1; flush_addr = flush_tgt; exp_addr = flush_tgt;
                flush_go = 0; post_flush = 1;
            end else begin
                flush = 0;
                if (cons_valid && (pop_mode == 1 || (pop_mode == 2 && cyc % 3 == 0) || pop_once)) begin
                    cons_pop = 1; pop_once = 0; pops++;
                    chk(cons_byte == mb(exp_addr), "R1 byte order", cons_byte, mb(exp_addr));
                    exp_addr = exp_addr + 16'd1;
                end
            end

            if (dreq_go && !d_req) begin
                d_req = 1; d_addr = 16'h8000 + 16'(cyc); d_we = cyc[0];
                d_wdata = 16'(cyc * 3); dreq_go = 0;
            end
        end
    end

    // Count data-done pulses, sampled just after the acknowledge is driven.
    always @(negedge clk) begin
        #1;
        if (rst_n && d_done) done_seen++;
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_code();
        do begin
            @(posedge clk); #1;
        end while (!(mem_req && mem_code));
    endtask

    // Fill from a target with no consumption, then pop until refetch.
    task automatic fill_case(input logic [15:0] tgt, input int pops_needed,
                             input logic [15:0] refetch, input string tag);
        int base;
        pop_mode = 0; lat = 0;
        run(40);
        base = code_starts;
        flush_tgt = tgt; flush_go = 1;
        run(40);
        chk(code_starts - base == 3, "R3 fill stops below two free slots", code_starts - base, 3);
        for (int i = 0; i < 10; i++) begin
            run(1);
            chk(!mem_req, "R2 no bus cycle while full", mem_req, 0);
        end
        for (int k = 1; k <= pops_needed; k++) begin
            pop_once = 1;
            run(6);
            if (k < pops_needed) begin
                chk(code_starts - base == 3, "R3 one free slot starts no fetch", code_starts - base, 3);
            end else begin
                chk(code_starts - base == 4, "R3 refetch once two slots free", code_starts - base, 4);
                chk(last_code_addr == refetch, tag, last_code_addr, refetch);
            end
        end
        pop_mode = 1;
        run(30);
    endtask

    initial begin
        int p0, a0, d0;
        rst_n = 0; cons_pop = 0; flush = 0; flush_addr = 0;
        d_req = 0; d_we = 0; d_addr = 0; d_wdata = 0; mem_ack = 0; mem_rdata = 0;
        repeat (4) @(posedge clk);
        #1;
        chk(!cons_valid && !mem_req, "R10 reset idle", {cons_valid, mem_req}, 0);
        rst_n = 1;

        // Streaming: consumer every cycle, then sparse (R8, R1).
        lat = 1; pop_mode = 1;
        run(200);
        chk(pops >= 100, "R8 pop and append in same cycle sustain the stream", pops, 100);
        pop_mode = 2;
        run(200);

        // Fill level and refetch threshold, even, odd, and across the wrap.
        fill_case(16'h1234, 2, 16'h123A, "R3 refetch offset even start");
        fill_case(16'h2001, 1, 16'h2006, "R6 odd start keeps one byte");
        p0 = pops;
        fill_case(16'hFFFD, 1, 16'h0002, "R9 offset wraps to zero");
        chk(pops - p0 >= 6, "R9 bytes consumed across wrap", pops - p0, 6);

        // Data request during a code read, at each in-flight cycle (R4).
        for (int k = 0; k < 3; k++) begin
            pop_mode = 0; lat = 3;
            run(60);
            a0 = data_acks; d0 = done_seen;
            flush_tgt = 16'h0400 + 16'(k * 64); flush_go = 1;
            wait_code();
            run(k);
            dreq_go = 1;
            run(30);
            chk(data_acks == a0 + 1, "R4 data access served", data_acks - a0, 1);
            chk(done_seen == d0 + 1, "R4 done pulse", done_seen - d0, 1);
            pop_mode = 1;
            run(30);
        end

        // Data request with a full queue (R2).
        pop_mode = 0; lat = 1;
        run(60);
        a0 = data_acks;
        dreq_go = 1;
        run(10);
        chk(data_acks == a0 + 1, "R2 data served while full", data_acks - a0, 1);

        // Flush at each cycle of an in-flight code read, including its ack (R7).
        for (int k = 0; k < 4; k++) begin
            pop_mode = 1; lat = 3;
            run(20);
            wait_code();
            run(k);
            p0 = pops;
            flush_tgt = 16'h5000 + 16'(k * 16'h0111);
            flush_go = 1;
            run(40);
            chk(pops - p0 >= 8, "R7 refill after flush of in-flight read", pops - p0, 8);
        end

        pop_mode = 1; lat = 0;
        run(50);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule